// File: doc/BRIEF.md
# Video Line Grab Freeze Controller

This block lets a video decoder capture one line of composite video and then replay it on every later line period. It drives the write enable and address of a one-line sample store and runs the subcarrier phase accumulator. In normal operation each pixel sample is written to the store and the accumulator adds the live increment on every sample. Once a grab is taken, the store is no longer written but its address keeps counting, so the frozen line is read back one sample per pixel. At each line start the accumulator also restarts from the increment and start phase that were latched when the grabbed line began.

A grab is armed by a control bit. By default the bit alone arms the grab. An external trigger pin takes over only when a 3-bit pin-function code holds the value 110 and a separate external-trigger enable bit is set. The freeze takes hold at the first line-start pulse after the grab is armed. Clearing the control bit releases the freeze at the next line start. While the control bit is set, the block also tells the decoding filters to fall back to a simple bandsplit mode. Sync generation, filtering and register access are handled by other blocks.

Top module: `lg_freeze_ctrl`

## Requirements
- R1: `bandsplit_mode` equals the value of `grab_en` sampled on the previous clock edge, and is 0 after reset.
- R2: With the external trigger not selected, a `line_start` pulse on a clock edge after the edge that first samples `grab_en` high starts the freeze. On that edge the accumulator loads `phase_in`, and `phase_in` and `seed_in` are latched.
- R3: With `ext_trig_en`=1 and `pin_func`=3'b110, line starts do not freeze the line until `trig_pin` has risen. A rise, held for at least five clocks before the next `line_start`, freezes the line at that line start.
- R4: If `ext_trig_en` is 0 or `pin_func` is not 3'b110, `trig_pin` has no effect and `grab_en` alone arms the grab, as in R2.
- R5: While frozen, `store_we` is 0 for every sample. When not frozen, `store_we` = `pix_valid` and not `line_start`.
- R6: `store_addr` becomes 0 after a `line_start` cycle. It rises by 1 after each cycle with `pix_valid`=1 and `line_start`=0, holds otherwise, and wraps from DEPTH-1 to 0.
- R7: When not frozen, `phase_out` adds the current `seed_in` after each sample cycle (`pix_valid`=1, `line_start`=0), wrapping modulo 2^PHASE_W. It holds on all other cycles, including line starts. It is 0 after reset.
- R8: While frozen, each `line_start` reloads `phase_out` with the latched phase, and each sample adds the latched increment. Later changes on `seed_in` and `phase_in` are ignored.
- R9: After `grab_en` is cleared, the freeze lasts until the next `line_start`. That line start leaves `phase_out` unchanged, and from then on writes resume and the live `seed_in` is added.
- R10: If `grab_en` is cleared before any line start while a grab is armed, the armed grab is dropped and a later line start does not freeze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grab_en | input | 1 | Line grab enable bit |
| ext_trig_en | input | 1 | External trigger enable bit |
| pin_func | input | FUNC_W | Pin-function code, 3'b110 selects the trigger |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| line_start | input | 1 | One-cycle line-start pulse |
| pix_valid | input | 1 | A pixel sample is present this cycle |
| seed_in | input | PHASE_W | Live accumulator increment |
| phase_in | input | PHASE_W | Live accumulator start phase |
| store_we | output | 1 | Line store write enable |
| store_addr | output | $clog2(DEPTH) | Line store read/write address |
| phase_out | output | PHASE_W | Subcarrier accumulator phase |
| bandsplit_mode | output | 1 | Decoder should use simple bandsplit |

## Verification
The bench checks that a second line start inside a grab returns the phase exactly to the latched value, even after the live increment and phase have been changed. A design that reloaded from the live inputs would drift instead of replaying. It checks that a line start before any pin rise leaves the line unfrozen in external mode, and that the pin is ignored when the pin-function code is wrong. It checks that an enable pulse withdrawn before any line start never freezes. It also checks the release edge: samples before the release line start must stay unwritten and use the latched increment, and the address must wrap at the store depth rather than run past it.

// File: rtl/lg_pkg.sv
package lg_pkg;
  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_ARMED  = 2'd1,
    GS_FROZEN = 2'd2
  } grab_state_t;
endpackage

// File: rtl/lg_trigger.sv
module lg_trigger
  import lg_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter logic [FUNC_W-1:0] EXT_CODE = 3'b110,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grab_en,
  input  logic              ext_en,
  input  logic [FUNC_W-1:0] pin_func,
  input  logic              trig_pin,
  input  logic              line_start,
  output logic              frozen,
  output logic              activate,
  output logic              reload
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  grab_state_t state_q, state_d;
  logic [CHAIN_W-1:0] sync_q, sync_d;
  logic ext_mode, trig_rise, arm_req;

  // pin synchronizer plus one delay stage for edge detect
  always_comb sync_d = {sync_q[CHAIN_W-2:0], trig_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign trig_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_mode  = ext_en && (pin_func == EXT_CODE);
  assign arm_req   = grab_en && (ext_mode ? trig_rise : 1'b1);

  always_comb begin
    state_d  = state_q;
    activate = 1'b0;
    reload   = 1'b0;
    unique case (state_q)
      GS_IDLE: begin
        if (arm_req) state_d = GS_ARMED;
      end
      GS_ARMED: begin
        if (!grab_en) state_d = GS_IDLE;
        else if (line_start) begin
          state_d  = GS_FROZEN;
          activate = 1'b1;
        end
      end
      GS_FROZEN: begin
        if (line_start) begin
          if (!grab_en) state_d = GS_IDLE;
          else          reload  = 1'b1;
        end
      end
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end

  assign frozen = (state_q == GS_FROZEN);

  // R2: an armed grab freezes on the line start
  assert_arm_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_ARMED && grab_en && line_start) |=> frozen);
  // R2: no freeze without first being armed
  assert_no_direct_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_IDLE) |=> !frozen);
  // R3: in external mode nothing arms without a pin edge
  assert_ext_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_IDLE && ext_mode && !trig_rise) |=> (state_q == GS_IDLE));
  // R9: release only at a line start with the enable low
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> ($past(line_start) && !$past(grab_en)));
  // R10: dropping the enable cancels an armed grab
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_ARMED && !grab_en) |=> (state_q == GS_IDLE));
endmodule

// File: rtl/lg_addr_gen.sv
module lg_addr_gen #(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              pix_valid,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic step_en;

  assign step_en = pix_valid & ~line_start;

  always_comb begin
    addr_d = addr_q;
    if (line_start)   addr_d = '0;
    else if (step_en) addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R6: line start clears the address
  assert_addr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (addr == '0));
  // R6: no sample, no movement
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !pix_valid) |=> $stable(addr));
  // R6: wrap at the last entry
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && addr == LAST) |=> (addr == '0));
endmodule

// File: rtl/lg_phase_acc.sv
module lg_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic               pix_valid,
  input  logic               frozen,
  input  logic               activate,
  input  logic               reload,
  input  logic [PHASE_W-1:0] seed_in,
  input  logic [PHASE_W-1:0] phase_in,
  output logic [PHASE_W-1:0] phase_out
);
  logic [PHASE_W-1:0] acc_q, acc_d;
  logic [PHASE_W-1:0] cap_seed_q, cap_phase_q;
  logic [PHASE_W-1:0] step_inc;
  logic sample;

  assign sample   = pix_valid & ~line_start;
  assign step_inc = frozen ? cap_seed_q : seed_in;

  // latch increment and start phase only when the freeze begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_seed_q  <= '0;
      cap_phase_q <= '0;
    end else if (activate) begin
      cap_seed_q  <= seed_in;
      cap_phase_q <= phase_in;
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (activate)    acc_d = phase_in;
    else if (reload) acc_d = cap_phase_q;
    else if (sample) acc_d = acc_q + step_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase_out = acc_q;

  // R7: live accumulation while not frozen
  assert_live_accum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && sample && !activate) |=> (phase_out == $past(phase_out) + $past(seed_in)));
  // R7: no reload on a line start outside a grab
  assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && line_start && !activate) |=> $stable(phase_out));
  // R8: each frozen line restarts from the latched phase
  assert_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (phase_out == $past(cap_phase_q)));
  // R8: latched values stay put during the grab
  assert_capture_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !activate) |=> ($stable(cap_seed_q) && $stable(cap_phase_q)));
endmodule

// File: rtl/lg_freeze_ctrl.sv
module lg_freeze_ctrl #(
  parameter int DEPTH = 1024,
  parameter int PHASE_W = 24,
  parameter int FUNC_W = 3,
  parameter logic [FUNC_W-1:0] EXT_CODE = 3'b110,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grab_en,
  input  logic               ext_trig_en,
  input  logic [FUNC_W-1:0]  pin_func,
  input  logic               trig_pin,
  input  logic               line_start,
  input  logic               pix_valid,
  input  logic [PHASE_W-1:0] seed_in,
  input  logic [PHASE_W-1:0] phase_in,
  output logic               store_we,
  output logic [ADDR_W-1:0]  store_addr,
  output logic [PHASE_W-1:0] phase_out,
  output logic               bandsplit_mode
);
  logic rst_meta_q, rst_sync_n;
  logic frozen, activate, reload;
  logic bandsplit_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lg_trigger #(
    .FUNC_W(FUNC_W), .EXT_CODE(EXT_CODE), .SYNC_STAGES(SYNC_STAGES)
  ) u_trigger (
    .clk(clk), .rst_n(rst_sync_n), .grab_en(grab_en), .ext_en(ext_trig_en),
    .pin_func(pin_func), .trig_pin(trig_pin), .line_start(line_start),
    .frozen(frozen), .activate(activate), .reload(reload)
  );

  lg_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .line_start(line_start),
    .pix_valid(pix_valid), .addr(store_addr)
  );

  lg_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .line_start(line_start), .pix_valid(pix_valid),
    .frozen(frozen), .activate(activate), .reload(reload),
    .seed_in(seed_in), .phase_in(phase_in), .phase_out(phase_out)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bandsplit_q <= 1'b0;
    else             bandsplit_q <= grab_en;
  end

  assign bandsplit_mode = bandsplit_q;
  assign store_we       = pix_valid & ~line_start & ~frozen;

  // R1: bandsplit indicator tracks the enable bit
  assert_bandsplit_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (bandsplit_mode == $past(grab_en)));
  // R5: the frozen store is never written
  assert_no_write_frozen_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (activate || reload) |=> !store_we);
endmodule

// File: tb/lg_freeze_ctrl_tb.sv
`timescale 1ns/1ps
module lg_freeze_ctrl_tb;
  localparam int DEPTH = 1024;
  localparam int PW = 24;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, grab_en, ext_trig_en, trig_pin, line_start, pix_valid;
  logic [2:0] pin_func;
  logic [PW-1:0] seed_in, phase_in;
  logic store_we, bandsplit_mode;
  logic [AW-1:0] store_addr;
  logic [PW-1:0] phase_out;

  int n_vec = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  lg_freeze_ctrl #(.DEPTH(DEPTH), .PHASE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .grab_en(grab_en), .ext_trig_en(ext_trig_en),
    .pin_func(pin_func), .trig_pin(trig_pin), .line_start(line_start),
    .pix_valid(pix_valid), .seed_in(seed_in), .phase_in(phase_in),
    .store_we(store_we), .store_addr(store_addr), .phase_out(phase_out),
    .bandsplit_mode(bandsplit_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ls);
    line_start = ls;
    pix_valid  = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  // one sample, checking the write enable before the edge
  task automatic sample(input string req, input logic exp_we);
    pix_valid = 1'b1;
    #1;
    chk(req, 32'(store_we), 32'(exp_we));
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; grab_en = 0; ext_trig_en = 0; trig_pin = 0; line_start = 0;
    pix_valid = 0; pin_func = 3'b000; seed_in = '0; phase_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 reset addr", 32'(store_addr), 0);
    chk("R7 reset phase", 32'(phase_out), 0);
    chk("R1 reset bandsplit", 32'(bandsplit_mode), 0);
    chk("R5 reset we", 32'(store_we), 0);
  endtask

  task automatic t_addr;
    step(1'b1);
    chk("R6 clear", 32'(store_addr), 0);
    repeat (3) sample("R5 live write", 1'b1);
    chk("R6 count", 32'(store_addr), 3);
    step(1'b0); step(1'b0);
    chk("R6 hold", 32'(store_addr), 3);
    step(1'b1);
    chk("R6 clear again", 32'(store_addr), 0);
    pix_valid = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) @(negedge clk);
    pix_valid = 1'b0;
    chk("R6 last entry", 32'(store_addr), DEPTH - 1);
    sample("R5 live write", 1'b1);
    chk("R6 wrap", 32'(store_addr), 0);
  endtask

  task automatic t_live_phase;
    logic [PW-1:0] base;
    seed_in = 24'h000105; phase_in = 24'h123456;
    base = phase_out;
    step(1'b1);
    chk("R7 no reload at line start", 32'(phase_out), 32'(base));
    repeat (5) sample("R5 live write", 1'b1);
    chk("R7 accumulate", 32'(phase_out), 32'(PW'(base + 5 * 24'h000105)));
    seed_in = 24'hFFFFF0;
    base = phase_out;
    sample("R5 live write", 1'b1);
    chk("R7 wrap add", 32'(phase_out), 32'(PW'(base + 24'hFFFFF0)));
  endtask

  task automatic t_bandsplit;
    grab_en = 1'b1;
    #1;
    chk("R1 not yet", 32'(bandsplit_mode), 0);
    @(negedge clk);
    chk("R1 on", 32'(bandsplit_mode), 1);
    grab_en = 1'b0;
    @(negedge clk);
    chk("R1 off", 32'(bandsplit_mode), 0);
  endtask

  task automatic t_grab_release;
    logic [PW-1:0] p0, s0, v;
    p0 = 24'h0ABCDE; s0 = 24'h000321;
    seed_in = s0; phase_in = p0;
    grab_en = 1'b1;
    step(1'b0); step(1'b0);
    step(1'b1);
    chk("R2 phase loaded", 32'(phase_out), 32'(p0));
    repeat (4) sample("R5 frozen no write", 1'b0);
    chk("R8 latched seed", 32'(phase_out), 32'(PW'(p0 + 4 * s0)));
    seed_in = 24'h000777; phase_in = 24'h111111;
    repeat (3) sample("R8 frozen no write", 1'b0);
    chk("R8 ignores live seed", 32'(phase_out), 32'(PW'(p0 + 7 * s0)));
    step(1'b1);
    chk("R8 replay phase", 32'(phase_out), 32'(p0));
    repeat (2) sample("R5 frozen no write", 1'b0);
    chk("R8 replay step", 32'(phase_out), 32'(PW'(p0 + 2 * s0)));
    chk("R6 frozen read addr", 32'(store_addr), 2);
    grab_en = 1'b0;
    sample("R9 still frozen", 1'b0);
    v = PW'(p0 + 3 * s0);
    chk("R9 latched seed until line", 32'(phase_out), 32'(v));
    step(1'b1);
    chk("R9 release no reload", 32'(phase_out), 32'(v));
    sample("R9 writes resume", 1'b1);
    chk("R9 live seed", 32'(phase_out), 32'(PW'(v + 24'h000777)));
  endtask

  task automatic t_ext_trigger;
    logic [PW-1:0] v;
    seed_in = 24'h000040; phase_in = 24'h055555;
    ext_trig_en = 1'b1; pin_func = 3'b110; trig_pin = 1'b0;
    grab_en = 1'b1;
    repeat (3) step(1'b0);
    v = phase_out;
    step(1'b1);
    chk("R3 no grab before pin", 32'(phase_out), 32'(v));
    sample("R3 still writing", 1'b1);
    trig_pin = 1'b1;
    repeat (5) step(1'b0);
    step(1'b1);
    chk("R3 pin grab phase", 32'(phase_out), 32'(24'h055555));
    sample("R3 frozen after pin", 1'b0);
    grab_en = 1'b0; trig_pin = 1'b0;
    step(1'b1);
    sample("R9 released", 1'b1);
    ext_trig_en = 1'b0; pin_func = 3'b000;
  endtask

  task automatic t_ext_ignored;
    seed_in = 24'h000010; phase_in = 24'h0F0F0F;
    ext_trig_en = 1'b1; pin_func = 3'b010; trig_pin = 1'b0;
    grab_en = 1'b1;
    repeat (2) step(1'b0);
    step(1'b1);
    chk("R4 grab without pin", 32'(phase_out), 32'(24'h0F0F0F));
    sample("R4 frozen", 1'b0);
    grab_en = 1'b0;
    step(1'b1);
    sample("R4 released", 1'b1);
    ext_trig_en = 1'b0; pin_func = 3'b000;
  endtask

  task automatic t_abort;
    logic [PW-1:0] v;
    seed_in = 24'h000003; phase_in = 24'h0AAAAA;
    grab_en = 1'b1;
    repeat (2) step(1'b0);
    grab_en = 1'b0;
    repeat (2) step(1'b0);
    v = phase_out;
    step(1'b1);
    chk("R10 no reload", 32'(phase_out), 32'(v));
    sample("R10 still writing", 1'b1);
    chk("R10 live add", 32'(phase_out), 32'(PW'(v + 24'h000003)));
  endtask

  initial begin
    t_reset();
    t_addr();
    t_live_phase();
    t_bandsplit();
    t_grab_release();
    t_ext_trigger();
    t_ext_ignored();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule